// File: doc/BRIEF.md
# Three-Lane Block FIR Filter

This block is a three-tap FIR filter that works on blocks of three consecutive samples. On each clock it can accept one block vector holding the samples at time indices 3k, 3k+1 and 3k+2. It then returns the three filter outputs for those same indices as one block. Because one clock carries three samples, the clock may run at one third of the sample rate. The clock period is therefore not the sampling period, which is what sets this structure apart from a pipelined filter.

The block keeps the last two samples of the most recently accepted block. Every output lane needs up to two samples from before its own block, and those two stored samples supply them. Each lane forms its own dot product of three coefficient-sample products, and all three lanes work in parallel. The coefficient inputs are expected to be held static, but they are sampled on the same edge as the block. Converting a serial stream into blocks, and blocks back into a serial stream, is left to the surrounding logic.

Top module: `blkfir_top`

## Requirements
- R1: After reset the output valid is 0, all three outputs read 0, and both stored history samples are 0.
- R2: outValid is 1 in exactly the cycle after an edge on which inValid was 1, and 0 after an edge on which inValid was 0.
- R3: Output lane 0 (outY0) equals h0·x(3k) + h1·x(3k-1) + h2·x(3k-2), where inS0 carries x(3k).
- R4: Output lane 1 (outY1) equals h0·x(3k+1) + h1·x(3k) + h2·x(3k-1), where inS1 carries x(3k+1).
- R5: Output lane 2 (outY2) equals h0·x(3k+2) + h1·x(3k+1) + h2·x(3k), where inS2 carries x(3k+2).
- R6: x(3k-1) and x(3k-2) are the inS2 and inS1 samples of the previously accepted block. For the first block after reset they are 0.
- R7: A cycle with inValid low leaves the stored history unchanged, so blocks separated by idle cycles filter as one continuous stream.
- R8: While inValid is low the three outputs keep their last values, even if the sample or coefficient inputs change.
- R9: Outputs are 2·W+2 bits signed. Full-scale negative samples and coefficients produce the exact sum without overflow.
- R10: Coefficients are sampled on the edge that accepts the block. A coefficient change during idle cycles first affects the next accepted block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one block per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Marks the block on inS0..inS2 as valid |
| inS0 | input | DATA_W | Sample x(3k), signed |
| inS1 | input | DATA_W | Sample x(3k+1), signed |
| inS2 | input | DATA_W | Sample x(3k+2), signed |
| coefH0 | input | DATA_W | Coefficient h0 (current sample), signed |
| coefH1 | input | DATA_W | Coefficient h1 (one sample back), signed |
| coefH2 | input | DATA_W | Coefficient h2 (two samples back), signed |
| outValid | output | 1 | Marks the output block as valid |
| outY0 | output | 2·DATA_W+2 | Output y(3k), signed |
| outY1 | output | 2·DATA_W+2 | Output y(3k+1), signed |
| outY2 | output | 2·DATA_W+2 | Output y(3k+2), signed |

## Verification
A single unit sample placed in lane 2, followed by a zero block, walks through the coefficients in order. This tells apart a swapped tap, a swapped lane, and history taken from the wrong lane of the previous block. Blocks of full-scale negative values show whether the output width and sign extension are right. Random blocks with random idle gaps check that history and outputs hold across gaps, and that coefficient changes made during a gap stay invisible until the next accepted block.

// File: rtl/blkfir_pkg.sv
package blkfir_pkg;
  localparam int LANES = 3;  // samples per block
  localparam int TAPS  = 3;  // filter length

  typedef struct packed {
    logic loadHist;  // capture the tail of the incoming block
    logic loadOut;   // capture the three lane sums
  } blkStrb_t;
endpackage

// File: rtl/blkfir_ctrl.sv
module blkfir_ctrl
  import blkfir_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output blkStrb_t strb,
  output logic     outValid
);
  always_comb begin
    strb.loadHist = inValid;
    strb.loadOut  = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2: valid follows an accepted block by one cycle
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
endmodule

// File: rtl/blkfir_dpath.sv
module blkfir_dpath
  import blkfir_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  blkStrb_t                      strb,
  input  logic signed [DATA_W-1:0]      sampIn [LANES],
  input  logic signed [DATA_W-1:0]      coef   [TAPS],
  output logic signed [2*DATA_W+1:0]    yOut   [LANES]
);
  localparam int OUT_W  = 2*DATA_W + 2;
  localparam int HIST_N = TAPS - 1;
  localparam int EXT_N  = LANES + HIST_N;

  logic signed [DATA_W-1:0] hist [HIST_N];  // hist[0] is the oldest
  logic signed [DATA_W-1:0] ext  [EXT_N];
  logic signed [OUT_W-1:0]  prod [LANES][TAPS];
  logic signed [OUT_W-1:0]  laneSum [LANES];

  // Stored history first, then the new block in time order
  always_comb begin
    for (int i = 0; i < HIST_N; i++) ext[i] = hist[i];
    for (int j = 0; j < LANES; j++)  ext[HIST_N+j] = sampIn[j];
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign prod[j][t] = OUT_W'(coef[t]) * OUT_W'(ext[HIST_N+j-t]);
    end
    always_comb begin
      laneSum[j] = '0;
      for (int t = 0; t < TAPS; t++) laneSum[j] = laneSum[j] + prod[j][t];
    end
    always_ff @(posedge clk) begin
      if (!rstN)             yOut[j] <= '0;
      else if (strb.loadOut) yOut[j] <= laneSum[j];
    end
    // R8: outputs hold while no block is accepted
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadOut |=> $stable(yOut[j]));
  end

  for (genvar i = 0; i < HIST_N; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rstN)              hist[i] <= '0;
      else if (strb.loadHist) hist[i] <= ext[LANES+i];
    end
    // R7: history untouched on idle cycles
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      !strb.loadHist |=> $stable(hist[i]));
    // R6: history takes the tail samples of the accepted block
    p_hist_load_r6: assert property (@(posedge clk) disable iff (!rstN)
      strb.loadHist |=> hist[i] == $past(sampIn[LANES-HIST_N+i]));
  end
endmodule

// File: rtl/blkfir_top.sv
module blkfir_top
  import blkfir_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic signed [DATA_W-1:0]   inS0,
  input  logic signed [DATA_W-1:0]   inS1,
  input  logic signed [DATA_W-1:0]   inS2,
  input  logic signed [DATA_W-1:0]   coefH0,
  input  logic signed [DATA_W-1:0]   coefH1,
  input  logic signed [DATA_W-1:0]   coefH2,
  output logic                       outValid,
  output logic signed [2*DATA_W+1:0] outY0,
  output logic signed [2*DATA_W+1:0] outY1,
  output logic signed [2*DATA_W+1:0] outY2
);
  blkStrb_t                 strb;
  logic signed [DATA_W-1:0] sampArr [LANES];
  logic signed [DATA_W-1:0] coefArr [TAPS];
  logic signed [2*DATA_W+1:0] yArr  [LANES];

  assign sampArr[0] = inS0;
  assign sampArr[1] = inS1;
  assign sampArr[2] = inS2;
  assign coefArr[0] = coefH0;
  assign coefArr[1] = coefH1;
  assign coefArr[2] = coefH2;
  assign outY0 = yArr[0];
  assign outY1 = yArr[1];
  assign outY2 = yArr[2];

  blkfir_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .outValid (outValid)
  );

  blkfir_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .sampIn (sampArr),
    .coef   (coefArr),
    .yOut   (yArr)
  );
endmodule

// File: tb/blkfir_top_tb_top.sv
`timescale 1ns/1ps
module blkfir_top_tb_top;
  localparam int DW = 16;
  localparam int OW = 2*DW + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inS0 = '0, inS1 = '0, inS2 = '0;
  logic signed [DW-1:0] coefH0 = '0, coefH1 = '0, coefH2 = '0;
  logic outValid;
  logic signed [OW-1:0] outY0, outY1, outY2;

  int total = 0;
  int bad = 0;
  longint mHistA = 0, mHistB = 0;  // x(3k-2), x(3k-1)
  longint eY0 = 0, eY1 = 0, eY2 = 0;
  logic eValid = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  blkfir_top #(.DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inS0(inS0), .inS1(inS1), .inS2(inS2),
    .coefH0(coefH0), .coefH1(coefH1), .coefH2(coefH2),
    .outValid(outValid), .outY0(outY0), .outY1(outY1), .outY2(outY2)
  );

  function automatic longint dot3(longint a, longint b, longint c,
                                  longint p, longint q, longint r);
    return a*p + b*q + c*r;
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge; applies one cycle and checks at the next negedge
  task automatic cycle(logic v, longint x0, longint x1, longint x2,
                       longint h0, longint h1, longint h2, string tag);
    inValid = v;
    inS0 = DW'(x0); inS1 = DW'(x1); inS2 = DW'(x2);
    coefH0 = DW'(h0); coefH1 = DW'(h1); coefH2 = DW'(h2);
    if (v) begin
      eY0 = dot3(h0, h1, h2, x0, mHistB, mHistA);
      eY1 = dot3(h0, h1, h2, x1, x0, mHistB);
      eY2 = dot3(h0, h1, h2, x2, x1, x0);
      mHistA = x1;
      mHistB = x2;
    end
    eValid = v;
    @(negedge clk);
    chk({"R2 valid ", tag}, longint'(outValid), longint'(eValid));
    chk({"R3 y0 ", tag}, longint'(outY0), eY0);
    chk({"R4 y1 ", tag}, longint'(outY1), eY1);
    chk({"R5 y2 ", tag}, longint'(outY2), eY2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = 32'h5eed_0b1c;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", longint'(outValid), 0);
    chk("R1 y0", longint'(outY0), 0);
    chk("R1 y1", longint'(outY1), 0);
    chk("R1 y2", longint'(outY2), 0);

    // R6: impulse in lane 2 walks taps through the next block; zero history at start
    cycle(1, 0, 0, 1, 3, 5, 7, "R6 impulse");
    cycle(1, 0, 0, 0, 3, 5, 7, "R6 tail");
    cycle(1, 0, 0, 0, 3, 5, 7, "R6 flush");
    // R7: history spans an idle gap
    cycle(1, 0, 2, 9, 3, 5, 7, "R7 prime");
    cycle(0, 11, 22, 33, 3, 5, 7, "R7 gap");
    cycle(0, 44, 55, 66, 3, 5, 7, "R7 gap");
    cycle(1, 1, 0, 0, 3, 5, 7, "R7 resume");
    // R10 / R8: coefficient change while idle is invisible until next block
    cycle(0, 7, 7, 7, -100, 200, -300, "R10 R8 idle coef");
    cycle(1, 4, -4, 8, -100, 200, -300, "R10 new coef");
    // R9: full-scale negative
    cycle(1, -32768, -32768, -32768, -32768, -32768, -32768, "R9 fullneg a");
    cycle(1, -32768, -32768, -32768, -32768, -32768, -32768, "R9 fullneg b");
    cycle(1, 32767, -32768, 32767, -32768, 32767, -32768, "R9 mixed");

    // Random blocks with random gaps
    for (int n = 0; n < 400; n++) begin
      logic v;
      longint a, b, c, p, q, r;
      v = ($urandom % 4) != 0;
      a = longint'($signed(16'($urandom)));
      b = longint'($signed(16'($urandom)));
      c = longint'($signed(16'($urandom)));
      p = longint'($signed(16'($urandom)));
      q = longint'($signed(16'($urandom)));
      r = longint'($signed(16'($urandom)));
      cycle(v, a, b, c, p, q, r, v ? "rand R6" : "rand R7 R8");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule